// File: doc/BRIEF.md
# Coprocessor Run-Control Register

This block sits next to a small RISC coprocessor core. It holds the run state of that core as the host CPU sees it. The host writes a 4-bit control word and reads back a 4-bit status word. Two of the bits are plain settings: forced activity and global interrupt enable. The other two act on write: a single-step launch and an acknowledge that clears the software-error flag.

From the core the block takes its idle indication, an instruction-retired strobe and an error strobe, plus the host's debug-mode request. It drives:
- a one-cycle step request;
- the debug level the core actually sees, which is lifted while one stepped instruction runs;
- a stall while an error is pending;
- a one-cycle thread-abort request when the error flag is cleared;
- an activity output that keeps the system out of stop mode;
- outgoing interrupts behind a global enable that never blocks the error interrupt.

Top module: `cop_runctl`

## Requirements
- R1: After reset the status word reads 0, no step is pending, no error is flagged, and step_req, thread_abort and core_stall are 0.
- R2: A host write with bit 3 set, made while dbg_req is 1 and no step is in progress, puts step_req high for exactly the next cycle and makes status bit 3 read 1 from that cycle on. The write is ignored when bit 3 is 0, when dbg_req is 0, or when a step is already in progress.
- R3: While a step is in progress, core_dbg is 0. The in-progress bit clears on the clock edge at which core_retire is seen high, and core_dbg then follows dbg_req again. Outside a step, core_dbg equals dbg_req.
- R4: activity is 1 when status bit 2 (force activity) is 1. Otherwise it is 1 exactly when core_idle is 0 and core_dbg is 0.
- R5: A core_err pulse sets the error flag (status bit 1) at the next edge. core_stall equals that flag.
- R6: A host write with bit 1 set clears the error flag. When core_err arrives in the same cycle, the set wins. thread_abort pulses for one cycle, in the cycle after the edge at which the flag actually falls from 1 to 0, and at no other time.
- R7: irq_out equals irq_src when status bit 0 (interrupt enable) is 1 and is all zeros otherwise. err_irq equals the error flag whatever the enable is.
- R8: Bits 2 and 0 take the written value on every host write and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 4 | Control word: 3 step, 2 force activity, 1 error acknowledge, 0 interrupt enable |
| rd_data | output | 4 | Status word: 3 step in progress, 2 force activity, 1 error flag, 0 interrupt enable |
| dbg_req | input | 1 | Host request to hold the core in debug mode |
| core_idle | input | 1 | Core has no thread running |
| core_retire | input | 1 | Core retired one instruction |
| core_err | input | 1 | Core detected a software error |
| irq_src | input | NIRQ | Interrupt requests from the core's threads |
| step_req | output | 1 | One-cycle request to execute one instruction |
| core_dbg | output | 1 | Debug level applied to the core |
| core_stall | output | 1 | Holds the core while an error is pending |
| thread_abort | output | 1 | One-cycle request to end the current thread |
| activity | output | 1 | Activity flag for the low-power controller |
| irq_out | output | NIRQ | Gated outgoing interrupts |
| err_irq | output | 1 | Software-error interrupt, never masked |

## Verification
All register state changes at the edge that samples the write or the core strobe. rd_data, core_stall, err_irq and core_dbg show the new value in the following cycle. step_req and thread_abort are registered one-cycle pulses, so each is high only in that same following cycle. activity and irq_out are combinational from the current inputs and state, so they respond in the cycle where the input changes. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output against that model on the next falling edge, which keeps each check on the cycle its result is due.

// File: rtl/cop_runctl.sv
module cop_runctl #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_data,
  output logic [3:0]      rd_data,
  input  logic            dbg_req,
  input  logic            core_idle,
  input  logic            core_retire,
  input  logic            core_err,
  input  logic [NIRQ-1:0] irq_src,
  output logic            step_req,
  output logic            core_dbg,
  output logic            core_stall,
  output logic            thread_abort,
  output logic            activity,
  output logic [NIRQ-1:0] irq_out,
  output logic            err_irq
);
  localparam int B_STEP = 3;
  localparam int B_FAKE = 2;
  localparam int B_ERR  = 1;
  localparam int B_IE   = 0;

  logic step_busy, fake_r, err_flag, ie_r;
  logic step_go, err_ack;

  assign step_go = wr_en && wr_data[B_STEP] && dbg_req && !step_busy;
  assign err_ack = wr_en && wr_data[B_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_busy <= 1'b0;
      step_req  <= 1'b0;
    end else begin
      step_req <= step_go;
      if (step_go)
        step_busy <= 1'b1;
      else if (step_busy && core_retire)
        step_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag     <= 1'b0;
      thread_abort <= 1'b0;
    end else begin
      thread_abort <= err_flag && err_ack && !core_err;
      if (core_err)
        err_flag <= 1'b1;
      else if (err_ack)
        err_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fake_r <= 1'b0;
      ie_r   <= 1'b0;
    end else if (wr_en) begin
      fake_r <= wr_data[B_FAKE];
      ie_r   <= wr_data[B_IE];
    end
  end

  assign rd_data    = {step_busy, fake_r, err_flag, ie_r};
  assign core_dbg   = dbg_req && !step_busy;
  assign core_stall = err_flag;
  assign activity   = fake_r || (!core_idle && !core_dbg);
  assign irq_out    = ie_r ? irq_src : '0;
  assign err_irq    = err_flag;

  AST_STEP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |=> !step_req); // R2
  AST_STEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> rd_data[3]); // R2
  AST_STEP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && core_retire && !step_req) |=> !rd_data[3]); // R3
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    core_err |=> (core_stall && err_irq)); // R5
  AST_ABORT_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    thread_abort |-> (!core_stall && $past(core_stall))); // R6
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> (irq_out == '0)); // R7
endmodule

// File: tb/cop_runctl_tb.sv
module cop_runctl_tb_top;
  localparam int NIRQ = 8;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [3:0] wr_data = 0;
  logic dbg_req = 0, core_idle = 1, core_retire = 0, core_err = 0;
  logic [NIRQ-1:0] irq_src = 0;
  logic [3:0] rd_data;
  logic step_req, core_dbg, core_stall, thread_abort, activity, err_irq;
  logic [NIRQ-1:0] irq_out;
  int checks = 0, errors = 0;
  bit m_busy, m_fake, m_err, m_ie, m_req, m_abort;

  always #5 clk = ~clk;

  cop_runctl #(.NIRQ(NIRQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dbg_req(dbg_req), .core_idle(core_idle), .core_retire(core_retire),
    .core_err(core_err), .irq_src(irq_src), .step_req(step_req), .core_dbg(core_dbg),
    .core_stall(core_stall), .thread_abort(thread_abort), .activity(activity),
    .irq_out(irq_out), .err_irq(err_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit go, ack;
      go  = wr_en && wr_data[3] && dbg_req && !m_busy;
      ack = wr_en && wr_data[1];
      m_req   = go;
      m_abort = m_err && ack && !core_err;
      if (go) m_busy = 1;
      else if (m_busy && core_retire) m_busy = 0;
      if (core_err) m_err = 1;
      else if (ack) m_err = 0;
      if (wr_en) begin m_fake = wr_data[2]; m_ie = wr_data[0]; end
    end
  end

  task automatic compare();
    bit dbg, act;
    dbg = dbg_req && !m_busy;
    act = m_fake || (!core_idle && !dbg);
    chk("R2 status", rd_data, {m_busy, m_fake, m_err, m_ie});
    chk("R2 step_req", step_req, m_req);
    chk("R3 core_dbg", core_dbg, dbg);
    chk("R4 activity", activity, act);
    chk("R5 core_stall", core_stall, m_err);
    chk("R6 thread_abort", thread_abort, m_abort);
    chk("R7 irq_out", irq_out, m_ie ? irq_src : '0);
    chk("R7 err_irq", err_irq, m_err);
  endtask

  task automatic step(input bit w, input logic [3:0] d, input bit dr, input bit idl,
                      input bit ret, input bit er, input logic [NIRQ-1:0] irq);
    @(negedge clk);
    compare();
    wr_en = w; wr_data = d; dbg_req = dr; core_idle = idl;
    core_retire = ret; core_err = er; irq_src = irq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", rd_data, 4'h0);
    chk("R1 reset step_req", step_req, 0);
    chk("R1 reset abort", thread_abort, 0);
    chk("R1 reset stall", core_stall, 0);
    rst_n = 1;
    // R8 plain bits written then read back
    step(1, 4'b0101, 0, 1, 0, 0, 8'hA5);
    step(0, 0, 0, 1, 0, 0, 8'hA5);
    chk("R8 fake/ie readback", rd_data & 4'b0101, 4'b0101);
    // R2 step ignored outside debug
    step(1, 4'b1000, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R2 step ignored without debug", rd_data[3], 0);
    // R2/R3 step in debug: pulse next cycle, debug lifted until retire
    step(1, 4'b1000, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R2 step pulse", step_req, 1);
    chk("R3 debug lifted", core_dbg, 0);
    step(1, 4'b1000, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0);
    chk("R2 second step while busy ignored", step_req, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R3 busy cleared on retire", rd_data[3], 0);
    chk("R3 debug restored", core_dbg, 1);
    // R5/R6 error, simultaneous set and clear, then real clear
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 4'b0010, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R6 set wins", core_stall, 1);
    chk("R6 no abort when set wins", thread_abort, 0);
    step(1, 4'b0010, 0, 0, 0, 0, 8'hFF);
    step(0, 0, 0, 0, 0, 0, 8'hFF);
    chk("R6 abort on real clear", thread_abort, 1);
    chk("R7 masked irq", irq_out, 0);
    step(1, 4'b0010, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R6 no abort on clear of clear flag", thread_abort, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] d;
      d = 4'($urandom);
      step(($urandom % 3) == 0, d, ($urandom % 4) != 0, $urandom % 2,
           ($urandom % 3) == 0, ($urandom % 16) == 0, NIRQ'($urandom));
    end
    step(0, 0, 0, 1, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule